// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns a core's code and data memory requests into strobe timing on a multiplexed external bus for an 8-bit controller with a 16-bit address space. It runs on the oscillator clock. Time is divided into six-clock bus windows, and two windows make one machine cycle. At the last clock of a window the block samples one command from the core. The command is idle, a code fetch, or a data read or write that uses either a 16-bit pointer or an 8-bit pointer.

Each window starts with an address-latch pulse while the low address byte sits on the shared low bus. A code fetch above the internal limit, or any fetch while the external-access input is low, asserts the program strobe and samples the returned byte from the bus. Other fetches are served from internal code memory and leave the program strobe idle. A data access spans two windows. It drives the read or write strobe and omits one latch pulse and two program strobes. The high byte carries address bits 15:8, or the current high-port register value for 8-bit-pointer accesses. Fetched bytes and read data return to the core as a registered one-clock response.

Top module: `xbus_seq`

## Requirements
- R1: While reset is asserted, and until the first command slot after its release, cmd_ack_o and ale_o are low, psen_n_o, rd_n_o and wr_n_o are high, ad_oe_o is low and rsp_valid_o is low.
- R2: ale_o is high in clocks 0 and 1 of every six-clock window and low in clocks 2 to 5. The one exception is the second window of a data access, where it stays low throughout, so exactly one pulse is omitted.
- R3: A command is sampled on the rising edge that ends a clock in which cmd_ack_o is high. cmd_ack_o is high only in the last clock of a window, except the first window of a data access. Fetch and idle commands occupy 6 clocks and data accesses occupy 12. The clocks of a command are numbered 0 to 11 from the clock after sampling.
- R4: A fetch is external when ea_i is low, or when its address is above 0x0FFF. Otherwise it is internal: psen_n_o stays high for the whole window and rom_addr_o shows the fetch address.
- R5: An external fetch drives psen_n_o low in clocks 2 to 5. The fetched byte is ad_i in clock 5 for an external fetch, or rom_data_i in clock 5 for an internal one.
- R6: During a data access psen_n_o stays high in both windows, so two program strobes are omitted. rd_n_o (reads) or wr_n_o (writes) is low from clock 3 through clock 10.
- R7: hi_o carries address bits 15:8 during an external fetch and during 16-bit-pointer accesses. In every other case it carries hi_reg_i: 8-bit-pointer accesses, internal fetches and idle windows.
- R8: ad_oe_o is high with ad_o equal to address bits 7:0 in clocks 0 and 1 of an external fetch or a data access. A write also drives req_wdata on ad_o in clocks 2 to 11. In every other clock ad_oe_o is low, which includes every clock in which psen_n_o or rd_n_o is low.
- R9: rsp_valid_o pulses for one clock. After a fetch it pulses in clock 0 of the next command, carrying the fetched byte. After a read it pulses in clock 11, carrying ad_i from clock 10. Writes and idle commands give no response.
- R10: req_kind encodes idle=0, fetch=1, read 16-bit pointer=2, read 8-bit pointer=3, write 16-bit pointer=4, write 8-bit pointer=5. Codes 6 and 7 behave as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_kind | input | 3 | Command code (R10) |
| req_addr | input | 16 | Fetch address or data pointer |
| req_wdata | input | 8 | Write data |
| ea_i | input | 1 | External-access select, low forces external fetches |
| hi_reg_i | input | 8 | Current high-port register value |
| ad_i | input | 8 | Low bus read value |
| rom_data_i | input | 8 | Byte from internal code memory |
| cmd_ack_o | output | 1 | Command is sampled at the end of this clock |
| rom_addr_o | output | 16 | Internal code memory address |
| ale_o | output | 1 | Address latch pulse, active high |
| psen_n_o | output | 1 | Program strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Low bus drive value |
| ad_oe_o | output | 1 | Low bus output enable |
| hi_o | output | 8 | High address byte |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_data_o | output | 8 | Fetched byte or read data |

## Verification
Directed fetches at 0x0FFF and 0x1000 with ea_i high, and at 0x0000 with ea_i low, separate the two routing conditions at the boundary. Each of the four data-access codes is run with a high-port value that differs from the pointer, which shows whether the high byte follows the address or the register. An unused code shows that it is treated as idle. A random mix of all codes, with addresses clustered near the boundary, follows. In that mix every command type comes after every other one, which exposes wrong window chaining, misplaced omitted pulses and response slots landing in the wrong clock. The bench changes ad_i on every clock, so a sample taken one clock early or late gives a wrong byte.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  parameter int unsigned XB_AW = 16;
  parameter int unsigned XB_DW = 8;

  typedef enum logic [2:0] {
    XK_IDLE  = 3'd0,
    XK_FETCH = 3'd1,
    XK_RD16  = 3'd2,
    XK_RD8   = 3'd3,
    XK_WR16  = 3'd4,
    XK_WR8   = 3'd5
  } xkind_e;

  typedef struct packed {
    xkind_e            kind;
    logic              ext;
    logic [XB_AW-1:0]  addr;
    logic [XB_DW-1:0]  wdata;
  } xop_t;

  function automatic xkind_e decode_kind(input logic [2:0] code);
    case (code)
      3'd1:    return XK_FETCH;
      3'd2:    return XK_RD16;
      3'd3:    return XK_RD8;
      3'd4:    return XK_WR16;
      3'd5:    return XK_WR8;
      default: return XK_IDLE;
    endcase
  endfunction

  function automatic logic kind_is_read(input xkind_e k);
    return (k == XK_RD16) || (k == XK_RD8);
  endfunction

  function automatic logic kind_is_write(input xkind_e k);
    return (k == XK_WR16) || (k == XK_WR8);
  endfunction

  function automatic logic kind_is_data(input xkind_e k);
    return kind_is_read(k) || kind_is_write(k);
  endfunction

  function automatic logic kind_is_wide(input xkind_e k);
    return (k == XK_RD16) || (k == XK_WR16);
  endfunction
endpackage

// File: rtl/xbus_timer.sv
module xbus_timer #(
  parameter int unsigned STATE_CLKS = 2,
  parameter int unsigned WIN_STATES = 3,
  localparam int unsigned WIN_CLKS  = STATE_CLKS * WIN_STATES,
  localparam int unsigned PW        = $clog2(WIN_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          long_op_i,
  output logic [PW-1:0] phase_o,
  output logic          second_o,
  output logic          load_o
);
  localparam logic [PW-1:0] LAST_PH = PW'(WIN_CLKS - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic          second_q, second_d;
  logic          win_end;

  always_comb begin
    win_end  = (phase_q == LAST_PH);
    load_o   = win_end && !(long_op_i && !second_q);
    phase_d  = win_end ? '0 : phase_q + 1'b1;
    second_d = second_q;
    if (win_end) begin
      second_d = long_op_i && !second_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= LAST_PH;
      second_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      second_q <= second_d;
    end
  end

  assign phase_o  = phase_q;
  assign second_o = second_q;

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST_PH) else $error("phase out of range"); // R3
  AST_SECOND_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(second_q) |-> (phase_q == '0) && ($past(phase_q) == LAST_PH)) else $error("second window misplaced"); // R3
endmodule

// File: rtl/xbus_cmd.sv
module xbus_cmd
  import xbus_pkg::*;
#(
  parameter logic [XB_AW-1:0] INT_TOP = 16'h0FFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [2:0]       req_kind,
  input  logic [XB_AW-1:0] req_addr,
  input  logic [XB_DW-1:0] req_wdata,
  input  logic             ea_i,
  output xop_t             op_o
);
  xop_t   op_q, op_d;
  xkind_e new_kind;
  logic   new_ext;

  always_comb begin
    new_kind = decode_kind(req_kind);
    if (new_kind == XK_FETCH) begin
      new_ext = !ea_i || (req_addr > INT_TOP);
    end else begin
      new_ext = kind_is_data(new_kind);
    end
    op_d = op_q;
    if (load_i) begin
      op_d.kind  = new_kind;
      op_d.ext   = new_ext;
      op_d.addr  = req_addr;
      op_d.wdata = req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q.kind  <= XK_IDLE;
      op_q.ext   <= 1'b0;
      op_q.addr  <= '0;
      op_q.wdata <= '0;
    end else begin
      op_q <= op_d;
    end
  end

  assign op_o = op_q;

  AST_EA_LOW_EXTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && (req_kind == 3'd1) && !ea_i |=> op_q.ext) else $error("ea low fetch not external"); // R4
  AST_LOW_PAGE_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && (req_kind == 3'd1) && ea_i && (req_addr <= INT_TOP) |=> !op_q.ext) else $error("low fetch not internal"); // R4
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int unsigned STATE_CLKS = 2,
  parameter int unsigned WIN_STATES = 3,
  localparam int unsigned WIN_CLKS  = STATE_CLKS * WIN_STATES,
  localparam int unsigned PW        = $clog2(WIN_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xop_t             op_i,
  input  logic [PW-1:0]    phase_i,
  input  logic             second_i,
  input  logic [XB_DW-1:0] hi_reg_i,
  input  logic [XB_DW-1:0] ad_i,
  input  logic [XB_DW-1:0] rom_data_i,
  output logic             ale_o,
  output logic             psen_n_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic [XB_DW-1:0] ad_o,
  output logic             ad_oe_o,
  output logic [XB_DW-1:0] hi_o,
  output logic [XB_AW-1:0] rom_addr_o,
  output logic             rsp_valid_o,
  output logic [XB_DW-1:0] rsp_data_o
);
  localparam logic [PW-1:0] LAST_PH  = PW'(WIN_CLKS - 1);
  localparam logic [PW-1:0] ALE_END  = PW'(STATE_CLKS);
  localparam logic [PW-1:0] STB_BEG  = PW'(WIN_CLKS / 2);
  localparam logic [PW-1:0] STB_END  = PW'(WIN_CLKS - 2);

  logic is_data, is_rd, is_wr, fetch_ext, addr_ph, wr_drive, stb_act;
  logic fetch_cap, read_cap;
  logic             rsp_valid_q, rsp_valid_d;
  logic [XB_DW-1:0] rsp_data_q, rsp_data_d;

  always_comb begin
    is_data   = kind_is_data(op_i.kind);
    is_rd     = kind_is_read(op_i.kind);
    is_wr     = kind_is_write(op_i.kind);
    fetch_ext = (op_i.kind == XK_FETCH) && op_i.ext;

    ale_o    = (phase_i < ALE_END) && !(is_data && second_i);
    psen_n_o = !(fetch_ext && (phase_i >= ALE_END));
    stb_act  = is_data && ((!second_i && (phase_i >= STB_BEG)) ||
                           (second_i && (phase_i <= STB_END)));
    rd_n_o   = !(stb_act && is_rd);
    wr_n_o   = !(stb_act && is_wr);

    addr_ph  = (fetch_ext || is_data) && !second_i && (phase_i < ALE_END);
    wr_drive = is_wr && (second_i || (phase_i >= ALE_END));
    ad_oe_o  = addr_ph || wr_drive;
    if (addr_ph) begin
      ad_o = op_i.addr[XB_DW-1:0];
    end else if (wr_drive) begin
      ad_o = op_i.wdata;
    end else begin
      ad_o = '0;
    end

    if (fetch_ext || kind_is_wide(op_i.kind)) begin
      hi_o = op_i.addr[XB_AW-1:XB_DW];
    end else begin
      hi_o = hi_reg_i;
    end
    rom_addr_o = op_i.addr;

    fetch_cap   = (op_i.kind == XK_FETCH) && (phase_i == LAST_PH);
    read_cap    = is_rd && second_i && (phase_i == STB_END);
    rsp_valid_d = fetch_cap || read_cap;
    rsp_data_d  = rsp_data_q;
    if (fetch_cap) begin
      rsp_data_d = op_i.ext ? ad_i : rom_data_i;
    end else if (read_cap) begin
      rsp_data_d = ad_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;

  AST_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n_o || !rd_n_o) |-> !ad_oe_o) else $error("bus driven during read strobe"); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n_o, !rd_n_o, !wr_n_o}) <= 1) else $error("strobes overlap"); // R6
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> psen_n_o && rd_n_o && wr_n_o) else $error("latch pulse during strobe"); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q |=> !rsp_valid_q) else $error("response longer than one clock"); // R9
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned      STATE_CLKS = 2,
  parameter int unsigned      WIN_STATES = 3,
  parameter logic [XB_AW-1:0] INT_TOP    = 16'h0FFF,
  localparam int unsigned     WIN_CLKS   = STATE_CLKS * WIN_STATES,
  localparam int unsigned     PW         = $clog2(WIN_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       req_kind,
  input  logic [XB_AW-1:0] req_addr,
  input  logic [XB_DW-1:0] req_wdata,
  input  logic             ea_i,
  input  logic [XB_DW-1:0] hi_reg_i,
  input  logic [XB_DW-1:0] ad_i,
  input  logic [XB_DW-1:0] rom_data_i,
  output logic             cmd_ack_o,
  output logic [XB_AW-1:0] rom_addr_o,
  output logic             ale_o,
  output logic             psen_n_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic [XB_DW-1:0] ad_o,
  output logic             ad_oe_o,
  output logic [XB_DW-1:0] hi_o,
  output logic             rsp_valid_o,
  output logic [XB_DW-1:0] rsp_data_o
);
  logic [1:0]    rsync_q;
  logic          rst_int_n;
  logic [PW-1:0] phase;
  logic          second;
  logic          load;
  xop_t          op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rsync_q[1];

  xbus_timer #(.STATE_CLKS(STATE_CLKS), .WIN_STATES(WIN_STATES)) timer_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .long_op_i (kind_is_data(op.kind)),
    .phase_o   (phase),
    .second_o  (second),
    .load_o    (load)
  );

  xbus_cmd #(.INT_TOP(INT_TOP)) cmd_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (load),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ea_i      (ea_i),
    .op_o      (op)
  );

  xbus_pins #(.STATE_CLKS(STATE_CLKS), .WIN_STATES(WIN_STATES)) pins_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .op_i        (op),
    .phase_i     (phase),
    .second_i    (second),
    .hi_reg_i    (hi_reg_i),
    .ad_i        (ad_i),
    .rom_data_i  (rom_data_i),
    .ale_o       (ale_o),
    .psen_n_o    (psen_n_o),
    .rd_n_o      (rd_n_o),
    .wr_n_o      (wr_n_o),
    .ad_o        (ad_o),
    .ad_oe_o     (ad_oe_o),
    .hi_o        (hi_o),
    .rom_addr_o  (rom_addr_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );

  assign cmd_ack_o = load && rst_int_n;

  AST_ACK_NOT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> !cmd_ack_o && !ale_o) else $error("activity during reset"); // R1
endmodule

// File: tb/xbus_seq_tb_top.sv
module xbus_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        ea_i;
  logic [7:0]  hi_reg_i;
  logic [7:0]  ad_i;
  logic [7:0]  rom_data_i;
  logic        cmd_ack_o;
  logic [15:0] rom_addr_o;
  logic        ale_o, psen_n_o, rd_n_o, wr_n_o, ad_oe_o, rsp_valid_o;
  logic [7:0]  ad_o, hi_o, rsp_data_o;

  int  n_chk = 0;
  int  n_err = 0;
  int  cyc   = 0;
  bit  finished = 1'b0;
  bit  pend_fetch = 1'b0;
  logic [7:0] pend_data = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .ea_i(ea_i), .hi_reg_i(hi_reg_i), .ad_i(ad_i),
    .rom_data_i(rom_data_i), .cmd_ack_o(cmd_ack_o), .rom_addr_o(rom_addr_o),
    .ale_o(ale_o), .psen_n_o(psen_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .hi_o(hi_o), .rsp_valid_o(rsp_valid_o),
    .rsp_data_o(rsp_data_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Runs one command, starting at a negedge where cmd_ack_o is high.
  task automatic run_op(input logic [2:0] kind, input logic [15:0] addr,
                        input logic [7:0] wd, input logic ea, input logic [7:0] hi,
                        input logic [7:0] adv, input logic [7:0] romv);
    bit is_f, is_d, is_r, is_w, wide, ext, exp_oe, ev;
    int n;
    string ptag;
    is_f = (kind == 3'd1);
    is_r = (kind == 3'd2) || (kind == 3'd3);
    is_w = (kind == 3'd4) || (kind == 3'd5);
    is_d = is_r || is_w;
    wide = (kind == 3'd2) || (kind == 3'd4);
    ext  = is_f && (!ea || (addr > 16'h0FFF));
    n    = is_d ? 12 : 6;
    if (kind > 3'd5)      ptag = "R10 psen_n";
    else if (is_d)        ptag = "R6 psen_n";
    else if (is_f && ext) ptag = "R5 psen_n";
    else if (is_f)        ptag = "R4 psen_n";
    else                  ptag = "R3 psen_n";
    req_kind = kind; req_addr = addr; req_wdata = wd; ea_i = ea; hi_reg_i = hi;
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk((kind > 3'd5) ? "R10 ale" : "R2 ale", int'(ale_o),
          int'(((k % 6) < 2) && !(is_d && k >= 6)));
      chk("R3 cmd_ack", int'(cmd_ack_o), int'(k == n - 1));
      chk(ptag, int'(psen_n_o), int'(!(ext && k >= 2)));
      chk("R6 rd_n", int'(rd_n_o), int'(!(is_r && k >= 3 && k <= 10)));
      chk("R6 wr_n", int'(wr_n_o), int'(!(is_w && k >= 3 && k <= 10)));
      exp_oe = ((ext || is_d) && k < 2) || (is_w && k >= 2);
      chk("R8 ad_oe", int'(ad_oe_o), int'(exp_oe));
      if (exp_oe) chk("R8 ad_o", int'(ad_o), (k < 2) ? int'(addr[7:0]) : int'(wd));
      chk("R7 hi_o", int'(hi_o), (ext || wide) ? int'(addr[15:8]) : int'(hi));
      if (is_f && !ext && k == 0) chk("R4 rom_addr", int'(rom_addr_o), int'(addr));
      ev = ((k == 0) && pend_fetch) || (is_r && k == 11);
      chk("R9 rsp_valid", int'(rsp_valid_o), int'(ev));
      if (ev) begin
        if (k == 0) chk("R5 fetched byte", int'(rsp_data_o), int'(pend_data));
        else        chk("R9 read byte", int'(rsp_data_o), int'(8'(adv + 8'd10)));
      end
      if (k == 0) begin
        pend_fetch = 1'b0;
        rom_data_i = romv;
      end
      ad_i = 8'(adv + 8'(k));
    end
    if (is_f) begin
      pend_fetch = 1'b1;
      pend_data  = ext ? 8'(adv + 8'd5) : romv;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not end, actual=%0d expected<=%0d cycles", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    int w;
    logic [2:0]  rk;
    logic [15:0] ra;
    rst_n = 1'b0; req_kind = 3'd0; req_addr = '0; req_wdata = '0;
    ea_i = 1'b1; hi_reg_i = 8'h5A; ad_i = '0; rom_data_i = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 cmd_ack", int'(cmd_ack_o), 0);
    chk("R1 ale", int'(ale_o), 0);
    chk("R1 psen_n", int'(psen_n_o), 1);
    chk("R1 rd_n", int'(rd_n_o), 1);
    chk("R1 wr_n", int'(wr_n_o), 1);
    chk("R1 ad_oe", int'(ad_oe_o), 0);
    chk("R1 rsp_valid", int'(rsp_valid_o), 0);
    rst_n = 1'b1;
    w = 0;
    while (!cmd_ack_o && w < 20) begin
      @(negedge clk);
      if (!cmd_ack_o) chk("R1 ale after release", int'(ale_o), 0);
      w++;
    end
    chk("R3 first slot", int'(cmd_ack_o), 1);

    // Directed corner cases
    run_op(3'd1, 16'h0FFF, 8'h00, 1'b1, 8'h5A, 8'h30, 8'hC3); // R4 internal at limit
    run_op(3'd1, 16'h1000, 8'h00, 1'b1, 8'h5A, 8'h40, 8'h11); // R4 external above limit
    run_op(3'd1, 16'h0000, 8'h00, 1'b0, 8'h5A, 8'h50, 8'h22); // R4 ea low
    run_op(3'd2, 16'hBEEF, 8'h00, 1'b1, 8'h77, 8'h60, 8'h00); // R6 R7 read wide
    run_op(3'd3, 16'hBE42, 8'h00, 1'b1, 8'h77, 8'h70, 8'h00); // R7 read 8-bit pointer
    run_op(3'd4, 16'h1234, 8'hA5, 1'b1, 8'h77, 8'h00, 8'h00); // R8 write wide
    run_op(3'd5, 16'h9988, 8'h3C, 1'b1, 8'h66, 8'h00, 8'h00); // R8 write 8-bit pointer
    run_op(3'd1, 16'h0800, 8'h00, 1'b1, 8'h66, 8'h10, 8'h99); // fetch before read
    run_op(3'd2, 16'h4321, 8'h00, 1'b0, 8'h66, 8'h20, 8'h00);
    run_op(3'd7, 16'hFFFF, 8'hFF, 1'b0, 8'h12, 8'h00, 8'h00); // R10 unused code
    run_op(3'd6, 16'h0001, 8'h01, 1'b0, 8'h13, 8'h00, 8'h00); // R10 unused code
    run_op(3'd0, 16'h0000, 8'h00, 1'b1, 8'h14, 8'h00, 8'h00);

    // Constrained random mix
    for (int i = 0; i < 300; i++) begin
      rk = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) ra = 16'(16'h0FF0 + $urandom_range(0, 31));
      else                           ra = 16'($urandom);
      run_op(rk, ra, 8'($urandom), 1'($urandom_range(0, 1)), 8'($urandom),
             8'($urandom), 8'($urandom));
    end
    run_op(3'd0, 16'h0000, 8'h00, 1'b1, 8'h00, 8'h00, 8'h00);
    finish_run();
  end
endmodule